// File: doc/BRIEF.md
# Serial Gain-Word Loader and Decoder

This block is the digital control front end of a programmable-gain line driver. A host writes a gain word over a three-wire serial port. The port has a serial clock, an active-low load strobe and a data line. The serial signals are brought into a faster system clock domain through two-stage synchronisers, and edges are detected there. While the strobe is low, each rising serial clock edge shifts one bit, most significant first, into a 7-bit register. Because the register holds only 7 bits, the first bit of an 8-bit word drops out and has no effect. When the strobe returns high, the register contents move into a gain latch in a single step.

The latched code is split into a coarse field (the upper four bits) and a fine field (the lower three bits). These are turned into coarse and fine attenuation step counts. The coarse step count clamps at zero once the coarse field passes 8. As a result, codes 0 to 71 give a linear gain ramp, and codes above 71 repeat the fine step in a sawtooth every eight codes.

Two mode inputs act without any clock. The transmit-enable input gates the forward-transmit output, and the active-low sleep input drives the sleep flag. Forward transmission is held off from reset until a first word has been latched.

Top module: `gainword_ctrl`

## Requirements
- R1: After reset, gain_code is 0, gain_valid is 0, fwd_tx is 0 and the attenuation outputs decode code 0 (coarse 8, fine 7).
- R2: While ser_load_n is low, each rising ser_clk edge shifts ser_dat into bit 0 of a 7-bit register and moves older bits one place up. An 8-bit word sent MSB first therefore leaves its lower 7 bits in the register, so words 128 to 255 latch the same code as the word minus 128.
- R3: A load with more than 8 clocks keeps only the last 7 bits shifted in.
- R4: A load aborted after n < 7 clocks latches the previous register contents shifted up by n places, with the n new bits in the low positions.
- R5: gain_code changes only on a rising edge of ser_load_n. While ser_load_n is low it holds its previous value.
- R6: ser_clk edges that arrive while ser_load_n is high leave the shift register unchanged.
- R7: coarse_atten is 8 minus gain_code[6:3] when that field is at most 8, and 0 otherwise.
- R8: fine_atten is 7 minus gain_code[2:0].
- R9: fwd_tx is high only when tx_en is high, sleep_n is high and gain_valid is high. Before the first latch, fwd_tx stays low whatever tx_en is.
- R10: sleep_mode equals the inverse of sleep_n without waiting for a clock edge, and fwd_tx is low whenever sleep_mode is high.
- R11: gain_valid is set by the first rising edge of ser_load_n after reset and stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_load_n | input | 1 | Active-low load strobe; its rising edge latches the word |
| ser_dat | input | 1 | Serial data, MSB first |
| tx_en | input | 1 | Transmit enable; 1 means forward transmit, 0 means between-burst |
| sleep_n | input | 1 | Active-low sleep request |
| gain_code | output | 7 | Latched gain code |
| coarse_atten | output | 4 | Coarse attenuation step count (0 to 8) |
| fine_atten | output | 3 | Fine attenuation step count (0 to 7) |
| gain_valid | output | 1 | A word has been latched since reset |
| fwd_tx | output | 1 | Forward transmission enabled |
| sleep_mode | output | 1 | Sleep mode active |

## Verification
The bench loads all 256 eight-bit words and compares the latched code and both step counts with arithmetic taken from the requirements. This sweep catches a design that keeps the wrong seven bits, which would make codes above 127 differ from codes below it. It also catches a design that saturates at the wrong field value, which would break the ramp at 71 or the sawtooth at 72 and 79.

Loads with extra clocks and loads cut short test whether the register shifts continuously without being cleared. A design that cleared it on the strobe's falling edge would latch zeros in the upper bits.

Clock pulses sent while the strobe is high, followed by an empty load, expose a design that shifts outside a load. The bench also samples the code in the middle of a load, which catches a latch that is transparent. Finally, the mode inputs are exercised before and after the first latch, which catches a design that transmits while its gain is still undefined.

// File: rtl/gw_pkg.sv
package gw_pkg;
  localparam int GW_CODE_W      = 7;  // bits kept by the shift register
  localparam int GW_FINE_W      = 3;  // vernier field width
  localparam int GW_COARSE_SPAN = 8;  // coarse field value giving zero coarse attenuation
  localparam int GW_SYNC_STAGES = 2;  // synchroniser depth
endpackage

// File: rtl/gw_sync.sv
module gw_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= chain_d;
    end

    assign dout[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gw_shift.sv
module gw_shift #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              ldn_s,
  input  logic              dat_s,
  output logic [CODE_W-1:0] latch_code,
  output logic              latch_valid,
  output logic              ld_rise
);
  logic              sck_p_q;
  logic              ldn_p_q;
  logic [CODE_W-1:0] sh_q, sh_d;
  logic [CODE_W-1:0] lat_q, lat_d;
  logic              vld_q, vld_d;
  logic              sck_rise;
  logic              shift_en;

  assign sck_rise = sck_s & ~sck_p_q;
  assign ld_rise  = ldn_s & ~ldn_p_q;
  assign shift_en = sck_rise & ~ldn_s;

  always_comb begin
    sh_d  = sh_q;
    lat_d = lat_q;
    vld_d = vld_q;
    if (shift_en) sh_d = {sh_q[CODE_W-2:0], dat_s};
    if (ld_rise) begin
      lat_d = sh_q;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p_q <= 1'b0;
      ldn_p_q <= 1'b1;
      sh_q    <= '0;
      lat_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      sck_p_q <= sck_s;
      ldn_p_q <= ldn_s;
      if (shift_en) sh_q  <= sh_d;
      if (ld_rise)  lat_q <= lat_d;
      if (ld_rise)  vld_q <= vld_d;
    end
  end

  assign latch_code  = lat_q;
  assign latch_valid = vld_q;
endmodule

// File: rtl/gw_decode.sv
module gw_decode #(
  parameter int CODE_W      = 7,
  parameter int FINE_W      = 3,
  parameter int COARSE_SPAN = 8,
  localparam int CRS_W      = CODE_W - FINE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [CRS_W-1:0]  coarse,
  output logic [FINE_W-1:0] fine
);
  localparam logic [CRS_W-1:0] SPAN = CRS_W'(COARSE_SPAN);

  logic [CRS_W-1:0]  crs_field;
  logic [FINE_W-1:0] fin_field;

  assign crs_field = code[CODE_W-1:FINE_W];
  assign fin_field = code[FINE_W-1:0];

  always_comb begin
    if (crs_field > SPAN) coarse = '0;
    else                  coarse = SPAN - crs_field;
    fine = {FINE_W{1'b1}} - fin_field;
  end
endmodule

// File: rtl/gainword_ctrl.sv
module gainword_ctrl
  import gw_pkg::*;
#(
  parameter int CODE_W      = GW_CODE_W,
  parameter int FINE_W      = GW_FINE_W,
  parameter int COARSE_SPAN = GW_COARSE_SPAN,
  parameter int SYNC_STAGES = GW_SYNC_STAGES,
  localparam int CRS_W      = CODE_W - FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_load_n,
  input  logic              ser_dat,
  input  logic              tx_en,
  input  logic              sleep_n,
  output logic [CODE_W-1:0] gain_code,
  output logic [CRS_W-1:0]  coarse_atten,
  output logic [FINE_W-1:0] fine_atten,
  output logic              gain_valid,
  output logic              fwd_tx,
  output logic              sleep_mode
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  logic [2:0] ser_s;
  logic       ld_rise;

  gw_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   ({ser_dat, ser_load_n, ser_clk}),
    .dout  (ser_s)
  );

  gw_shift #(
    .CODE_W (CODE_W)
  ) i_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sck_s       (ser_s[0]),
    .ldn_s       (ser_s[1]),
    .dat_s       (ser_s[2]),
    .latch_code  (gain_code),
    .latch_valid (gain_valid),
    .ld_rise     (ld_rise)
  );

  gw_decode #(
    .CODE_W      (CODE_W),
    .FINE_W      (FINE_W),
    .COARSE_SPAN (COARSE_SPAN)
  ) i_decode (
    .code   (gain_code),
    .coarse (coarse_atten),
    .fine   (fine_atten)
  );

  // mode outputs follow their inputs without a clock
  assign sleep_mode = ~sleep_n;
  assign fwd_tx     = tx_en & sleep_n & gain_valid;
endmodule

// File: rtl/gw_checker.sv
module gw_checker #(
  parameter int CODE_W = 7,
  parameter int CRS_W  = 4,
  parameter int SPAN   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] gain_code,
  input logic [CRS_W-1:0]  coarse_atten,
  input logic              gain_valid,
  input logic              fwd_tx,
  input logic              sleep_mode,
  input logic              ld_rise
);
  AST_TX_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_valid |-> !fwd_tx);                                   // R9

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    gain_valid |=> gain_valid);                                 // R11

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(gain_code));                           // R5

  AST_COARSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_atten <= CRS_W'(SPAN));                              // R7

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode |-> !fwd_tx);                                    // R10
endmodule

bind gainword_ctrl gw_checker #(
  .CODE_W (CODE_W),
  .CRS_W  (CRS_W),
  .SPAN   (COARSE_SPAN)
) i_gw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .gain_code    (gain_code),
  .coarse_atten (coarse_atten),
  .gain_valid   (gain_valid),
  .fwd_tx       (fwd_tx),
  .sleep_mode   (sleep_mode),
  .ld_rise      (ld_rise)
);

// File: tb/test_gainword_ctrl.sv
module test_gainword_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_load_n = 1'b1;
  logic       ser_dat = 1'b0;
  logic       tx_en = 1'b0;
  logic       sleep_n = 1'b1;
  logic [6:0] gain_code;
  logic [3:0] coarse_atten;
  logic [2:0] fine_atten;
  logic       gain_valid;
  logic       fwd_tx;
  logic       sleep_mode;

  int checks = 0;
  int errors = 0;
  logic [6:0] model_sh = '0;  // expected shift register contents
  logic [6:0] model_code = '0;

  always #4 clk = ~clk;  // 125 MHz

  gainword_ctrl i_gainword_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_load_n(ser_load_n),
    .ser_dat(ser_dat), .tx_en(tx_en), .sleep_n(sleep_n),
    .gain_code(gain_code), .coarse_atten(coarse_atten), .fine_atten(fine_atten),
    .gain_valid(gain_valid), .fwd_tx(fwd_tx), .sleep_mode(sleep_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    ser_dat = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
    wait_clk(4);
  endtask

  // shifts the low n bits of bits, MSB first, inside one load
  task automatic load_word(input logic [15:0] bits, input int n);
    ser_load_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      pulse_bit(bits[i]);
      model_sh = {model_sh[5:0], bits[i]};
    end
    ser_load_n = 1'b1;
    model_code = model_sh;
    wait_clk(8);
  endtask

  function automatic int exp_coarse(input int c);
    return ((c >> 3) <= 8) ? 8 - (c >> 3) : 0;
  endfunction

  function automatic int exp_fine(input int c);
    return 7 - (c & 7);
  endfunction

  task automatic check_decode(input string req, input int word);
    int c;
    c = word % 128;
    check({req, " code"}, gain_code, c);
    check({req, " coarse"}, coarse_atten, exp_coarse(c));
    check({req, " fine"}, fine_atten, exp_fine(c));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check("R1 code", gain_code, 0);
    check("R1 valid", gain_valid, 0);
    check("R1 coarse", coarse_atten, 8);
    check("R1 fine", fine_atten, 7);
    // R9 transmit blocked before first latch
    tx_en = 1'b1;
    #1 check("R9 blocked before valid", fwd_tx, 0);
    tx_en = 1'b0;

    // R2 R7 R8 exhaustive sweep of 8-bit words
    for (int w = 0; w < 256; w++) begin
      load_word(16'(w), 8);
      check_decode("R2/R7/R8 sweep", w);
    end
    check("R11 valid set", gain_valid, 1);

    // named decode points R7 R8
    load_word(16'd0, 8);   check_decode("R7 code0", 0);
    load_word(16'd70, 8);  check_decode("R7 code70", 70);
    load_word(16'd71, 8);  check_decode("R7 code71", 71);
    load_word(16'd72, 8);  check_decode("R8 code72", 72);
    load_word(16'd79, 8);  check_decode("R8 code79", 79);
    load_word(16'd127, 8); check_decode("R8 code127", 127);
    load_word(16'd200, 8); check_decode("R2 code200", 200);

    // R3 extra clocks: 11 bits, last 7 kept
    load_word(16'b101_1100_1010, 11);
    check("R3 extra clocks", gain_code, 7'b1001010);
    check("R3 model", gain_code, model_code);

    // R4 aborted load of 3 bits
    load_word(16'd85, 8);            // register = 1010101
    load_word(16'b011, 3);           // expect 0101011
    check("R4 aborted load", gain_code, 7'b0101011);

    // R5 latch holds during load
    load_word(16'd33, 8);
    ser_load_n = 1'b0;
    wait_clk(4);
    pulse_bit(1'b1); pulse_bit(1'b1); pulse_bit(1'b0);
    model_sh = {model_sh[3:0], 3'b110};
    check("R5 hold mid-load", gain_code, 33);
    ser_load_n = 1'b1;
    wait_clk(8);
    model_code = model_sh;
    check("R5 update on strobe rise", gain_code, model_code);

    // R6 clocks while strobe high are ignored
    load_word(16'd99, 8);
    pulse_bit(1'b1); pulse_bit(1'b0); pulse_bit(1'b1);
    load_word(16'd0, 0);             // empty load latches register as is
    check("R6 idle clocks ignored", gain_code, 99);

    // R9 R10 mode outputs
    tx_en = 1'b1; sleep_n = 1'b1;
    #1 check("R9 transmit on", fwd_tx, 1);
    sleep_n = 1'b0;
    #1 check("R10 sleep flag", sleep_mode, 1);
    check("R10 sleep blocks tx", fwd_tx, 0);
    sleep_n = 1'b1;
    #1 check("R10 wake", sleep_mode, 0);
    tx_en = 1'b0;
    #1 check("R9 between-burst", fwd_tx, 0);

    // R1 R11 reset clears valid again
    rst_n = 1'b0;
    wait_clk(3);
    check("R11 cleared by reset", gain_valid, 0);
    check("R1 code after reset", gain_code, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule